// File: doc/BRIEF.md
# Compare-Driven PWM Channel Sequencer

This block drives one pulse-width-modulated pin from a free-running 16-bit timebase without owning a period counter. Its edges are placed by a single compare register that holds an absolute timebase value. Each new cycle is chained off the time of the previous rise. Software programs a period and a high time through a small write port. A start strobe then begins the waveform on one of two timebase inputs, and the block raises a one-cycle interrupt once per period.

Zero and full duty are treated as steady levels. The pin is forced to its level and a compare that leaves the pin untouched is armed one period later. At that compare the duty is re-evaluated from fresh settings, so the level never depends on how quickly a response arrives. An update strobe lets software apply new settings in the middle of a period. The strobe moves the pending edge at once instead of waiting for the next period boundary.

Top module: `pwm_cmp_chan`

## Requirements
- R1: After reset the pin and the interrupt are low, and they stay low while the timebase runs until a start strobe arrives.
- R2: Register map on `wr_addr`: 0 holds the timebase select in bit 0 (0 selects `tb_a`, 1 selects `tb_b`), 1 holds the period and 2 holds the high time. A start strobe latches the select, takes the selected timebase value as the rise time, drives the pin high unless the high time is zero, and pulses the interrupt on the next cycle.
- R3: In normal duty (0 < high < period), the pin falls exactly `high` ticks after each rise and rises again `period` ticks after that rise. The interrupt pulses only in the clock that follows a rise, and never at a fall.
- R4: A high time of zero holds the pin low and pulses the interrupt every `period` ticks.
- R5: A high time greater than or equal to the period holds the pin high and pulses the interrupt every `period` ticks.
- R6: At a zero- or full-duty period compare, the settings are evaluated again. Coming from full duty, a normal setting makes the pin fall `high` ticks after that compare. Coming from zero duty, the pin stays low for one more period and then resumes normal pulses.
- R7: An update strobe with the pin high and no compare firing re-arms the fall at the last rise time plus the new high time, and pulses the interrupt.
- R8: An update strobe with the pin low in normal duty re-arms the rise at the last rise time plus the new period, and pulses the interrupt.
- R9: An update strobe with the pin high, in the same cycle as a compare firing, is handled as a rise at the compare time. The next fall is then `high` ticks after that compare.
- R10: An update strobe with the pin low, in zero or full duty and in the same cycle as a compare firing, is handled as a period compare at the compare time.
- R11: All compare times wrap modulo 2^16, so a cycle that crosses the timebase rollover keeps its timing.
- R12: A register write takes effect at the clock edge. An evaluation in that same edge uses the period and high time held before the write, as one consistent pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 period, 2 high time) |
| wr_data | input | 16 | Write data |
| init_req | input | 1 | Start strobe |
| upd_req | input | 1 | Immediate-update strobe |
| tb_a | input | 16 | Timebase 0 |
| tb_b | input | 16 | Timebase 1 |
| pin | output | 1 | PWM output |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
An update strobe can land in the same clock as a compare match, and the two then compete for the rise time and the pin level. The bench provokes this by timing the strobe at the edge where the timebase equals the armed fall, with the pin high. It does the same at the period compare of a zero-duty waveform, with the pin low. It judges the result by the clocks at which the pin later falls and rises, and by the interrupt pulses. Both depend on whether the compare time, and not the old rise time, became the new reference.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_FALL = 2'd1,
    ARM_RISE = 2'd2,
    ARM_HOLD = 2'd3
  } arm_t;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_PER  = 1;
  localparam int unsigned REG_HIGH = 2;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int TW   = 16,
  parameter int AW   = 2,
  parameter int SELW = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [TW-1:0]   wr_data,
  output logic [SELW-1:0] sel_q,
  output logic [TW-1:0]   per_q,
  output logic [TW-1:0]   hi_q
);
  import pwm_seq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      per_q <= '0;
      hi_q  <= '0;
    end else if (wr_en) begin
      case (int'(wr_addr))
        REG_CTRL: sel_q <= wr_data[SELW-1:0];
        REG_PER:  per_q <= wr_data;
        REG_HIGH: hi_q  <= wr_data;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_tb_match.sv
module pwm_tb_match #(
  parameter int TW   = 16,
  parameter int NTB  = 2,
  parameter int SELW = 1
) (
  input  logic [NTB-1:0][TW-1:0] tb_vec,
  input  logic [SELW-1:0]        run_sel,
  input  logic [SELW-1:0]        cfg_sel,
  input  logic [TW-1:0]          cmp,
  input  logic                   armed,
  output logic [TW-1:0]          start_time,
  output logic                   hit
);
  logic [NTB-1:0] eq;

  for (genvar g = 0; g < NTB; g++) begin : g_eq
    assign eq[g] = (tb_vec[g] == cmp);
  end

  assign hit        = armed && eq[run_sel];
  assign start_time = tb_vec[cfg_sel];
endmodule

// File: rtl/pwm_duty_eval.sv
module pwm_duty_eval #(
  parameter int TW = 16
) (
  input  logic [TW-1:0]     base,
  input  logic [TW-1:0]     per,
  input  logic [TW-1:0]     hi,
  input  logic              low_path,
  output logic              pin_n,
  output logic              special_n,
  output logic [TW-1:0]     cmp_n,
  output logic [TW-1:0]     rise_n,
  output pwm_seq_pkg::arm_t arm_n
);
  import pwm_seq_pkg::*;

  logic zero_duty, full_duty;

  always_comb begin
    zero_duty = (hi == '0);
    full_duty = !zero_duty && (hi >= per);
    special_n = zero_duty || full_duty;
    rise_n    = base + per;
    if (special_n) begin
      pin_n = full_duty;
      cmp_n = base + per;
      arm_n = ARM_HOLD;
    end else if (low_path) begin
      pin_n = 1'b0;
      cmp_n = base + per;
      arm_n = ARM_RISE;
    end else begin
      pin_n = 1'b1;
      cmp_n = base + hi;
      arm_n = ARM_FALL;
    end
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int TW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic          init_req,
  input  logic          upd_req,
  input  logic [TW-1:0] tb_a,
  input  logic [TW-1:0] tb_b,
  output logic          pin,
  output logic          irq
);
  import pwm_seq_pkg::*;

  localparam int NTB  = 2;
  localparam int SELW = $clog2(NTB);

  logic [SELW-1:0]        cfg_sel, run_sel_q;
  logic [TW-1:0]          per_q, hi_q;
  logic [NTB-1:0][TW-1:0] tb_vec;
  logic [TW-1:0]          cmp_q, last_q, next_rise_q, start_time;
  arm_t                   arm_q;
  logic                   special_q, hit;

  logic          do_eval, take_base, low_path, do_fall;
  logic [TW-1:0] base;
  logic          ev_pin, ev_special;
  logic [TW-1:0] ev_cmp, ev_rise;
  arm_t          ev_arm;

  assign tb_vec[0] = tb_a;
  assign tb_vec[1] = tb_b;

  pwm_cfg_regs #(.TW(TW), .AW(AW), .SELW(SELW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_q(cfg_sel), .per_q(per_q), .hi_q(hi_q)
  );

  pwm_tb_match #(.TW(TW), .NTB(NTB), .SELW(SELW)) u_match (
    .tb_vec(tb_vec), .run_sel(run_sel_q), .cfg_sel(cfg_sel), .cmp(cmp_q),
    .armed(arm_q != ARM_NONE), .start_time(start_time), .hit(hit)
  );

  pwm_duty_eval #(.TW(TW)) u_eval (
    .base(base), .per(per_q), .hi(hi_q), .low_path(low_path),
    .pin_n(ev_pin), .special_n(ev_special), .cmp_n(ev_cmp), .rise_n(ev_rise),
    .arm_n(ev_arm)
  );

  // Event arbitration: start strobe, then update strobe, then compare.
  always_comb begin
    do_eval   = 1'b0;
    take_base = 1'b0;
    low_path  = 1'b0;
    do_fall   = 1'b0;
    base      = last_q;
    if (init_req) begin
      do_eval   = 1'b1;
      take_base = 1'b1;
      base      = start_time;
    end else if (upd_req) begin
      do_eval = 1'b1;
      if (pin) begin
        if (hit) begin
          take_base = 1'b1;
          base      = cmp_q;
        end
      end else begin
        low_path = 1'b1;
        if (hit && special_q) begin
          take_base = 1'b1;
          base      = cmp_q;
        end
      end
    end else if (hit) begin
      case (arm_q)
        ARM_FALL: do_fall = 1'b1;
        ARM_RISE: begin
          do_eval   = 1'b1;
          take_base = 1'b1;
          base      = cmp_q;
        end
        ARM_HOLD: begin
          do_eval   = 1'b1;
          take_base = 1'b1;
          base      = cmp_q;
          low_path  = !pin;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin         <= 1'b0;
      irq         <= 1'b0;
      arm_q       <= ARM_NONE;
      special_q   <= 1'b0;
      cmp_q       <= '0;
      last_q      <= '0;
      next_rise_q <= '0;
      run_sel_q   <= '0;
    end else begin
      irq <= 1'b0;
      if (do_eval) begin
        pin         <= ev_pin;
        cmp_q       <= ev_cmp;
        arm_q       <= ev_arm;
        special_q   <= ev_special;
        next_rise_q <= ev_rise;
        irq         <= 1'b1;
        if (take_base) last_q <= base;
        if (init_req) run_sel_q <= cfg_sel;
      end else if (do_fall) begin
        pin   <= 1'b0;
        cmp_q <= next_rise_q;
        arm_q <= ARM_RISE;
      end
    end
  end
endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          init_req,
  input logic          upd_req,
  input logic          pin,
  input logic          irq,
  input logic          hit,
  input logic [1:0]    arm_q,
  input logic [TW-1:0] per_q,
  input logic [TW-1:0] hi_q
);
  import pwm_seq_pkg::*;

  logic quiet, hold_ev;
  assign quiet   = !init_req && !upd_req;
  assign hold_ev = init_req || (quiet && hit && arm_q == ARM_HOLD);

  assert_start_irq_R2: assert property (@(posedge clk) disable iff (rst)
    init_req && hi_q != '0 |=> pin && irq);

  assert_fall_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    quiet && hit && arm_q == ARM_FALL |=> !pin && !irq);

  assert_rise_irq_R3: assert property (@(posedge clk) disable iff (rst)
    quiet && hit && arm_q == ARM_RISE |=> pin && irq);

  assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
    hold_ev && hi_q == '0 |=> !pin && irq);

  assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
    hold_ev && hi_q != '0 && hi_q >= per_q |=> pin && irq);
endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .init_req(init_req), .upd_req(upd_req),
  .pin(pin), .irq(irq), .hit(hit), .arm_q(arm_q), .per_q(per_q), .hi_q(hi_q)
);

// File: tb/sim_pwm_cmp_chan.sv
`timescale 1ns/1ps
module sim_pwm_cmp_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        init_req = 1'b0, upd_req = 1'b0;
  logic [15:0] tb_a = '0, tb_b = '0;
  logic        run_a = 1'b1, run_b = 1'b0;
  logic        pin, irq;

  int checks = 0, errors = 0, n = 0;

  always #2.5 clk = ~clk;

  pwm_cmp_chan u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .init_req(init_req), .upd_req(upd_req), .tb_a(tb_a), .tb_b(tb_b),
    .pin(pin), .irq(irq)
  );

  function automatic logic exp_pin(int per, int hi, int k);
    if (hi == 0) return 1'b0;
    if (hi >= per) return 1'b1;
    return (k % per) < hi;
  endfunction

  function automatic logic exp_irq(int per, int k);
    return (k % per) == 0;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at offset %0d: actual %0b expected %0b", tag, n, act, exp);
    end
  endtask

  // One clock: inputs set beforehand are sampled at this edge.
  task automatic step();
    @(posedge clk);
    #1;
    wr_en = 1'b0; init_req = 1'b0; upd_req = 1'b0;
    if (run_a) tb_a = tb_a + 16'd1;
    if (run_b) tb_b = tb_b + 16'd1;
    n++;
  endtask

  task automatic adv_to(input int k);
    while (n < k) step();
  endtask

  task automatic set_wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
  endtask

  task automatic start(input int per, input int hi);
    set_wr(1, per); step();
    set_wr(2, hi);  step();
    init_req = 1'b1; step();
    n = 0;
  endtask

  task automatic run_model(input int per, input int hi, input int len, input string tag);
    chk(pin, exp_pin(per, hi, 0), tag);
    chk(irq, 1'b1, tag);
    for (int k = 1; k <= len; k++) begin
      step();
      chk(pin, exp_pin(per, hi, n), tag);
      chk(irq, exp_irq(per, n), tag);
    end
  endtask

  function automatic string duty_tag(int per, int hi);
    if (hi == 0) return "R4";
    if (hi >= per) return "R5";
    return "R3";
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20931));
    step(); step(); step();
    rst = 1'b0;
    // R1: idle after reset
    for (int k = 0; k < 30; k++) begin
      step();
      chk(pin, 1'b0, "R1");
      chk(irq, 1'b0, "R1");
    end

    // R3 R4 R5 directed corners
    start(12, 5);  run_model(12, 5, 36, "R3");
    start(9, 0);   run_model(9, 0, 27, "R4");
    start(9, 9);   run_model(9, 9, 27, "R5");
    start(9, 40);  run_model(9, 40, 27, "R5");

    // R11: cycles crossing the timebase rollover
    tb_a = 16'hFFF5;
    start(20, 7);  run_model(20, 7, 60, "R11");

    // random duty and period
    for (int it = 0; it < 12; it++) begin
      int p, h;
      p = 2 + int'($urandom % 30);
      h = int'($urandom % (p + 4));
      start(p, h);
      run_model(p, h, 3 * p, duty_tag(p, h));
    end

    // R2: second timebase selected, first frozen
    set_wr(0, 1); step();
    run_a = 1'b0; run_b = 1'b1; tb_b = 16'h4000;
    start(8, 3); run_model(8, 3, 24, "R2");
    set_wr(0, 0); step();
    run_a = 1'b1; run_b = 1'b0;

    // R7: update with pin high moves the fall
    start(20, 10);
    adv_to(2); set_wr(2, 5); step();
    upd_req = 1'b1; step();
    chk(irq, 1'b1, "R7"); chk(pin, 1'b1, "R7");
    step(); chk(pin, 1'b0, "R7");
    adv_to(20); chk(pin, 1'b1, "R7");
    adv_to(25); chk(pin, 1'b0, "R7");

    // R8: update with pin low moves the rise
    start(20, 5);
    adv_to(9); set_wr(1, 30); step();
    upd_req = 1'b1; step();
    chk(irq, 1'b1, "R8"); chk(pin, 1'b0, "R8");
    adv_to(20); chk(pin, 1'b0, "R8");
    adv_to(29); chk(pin, 1'b0, "R8");
    adv_to(30); chk(pin, 1'b1, "R8"); chk(irq, 1'b1, "R8");
    adv_to(35); chk(pin, 1'b0, "R8");

    // R12: write at the rise edge is seen one period later
    start(20, 10);
    adv_to(19); set_wr(2, 3); step();
    chk(pin, 1'b1, "R12"); chk(irq, 1'b1, "R12");
    adv_to(23); chk(pin, 1'b1, "R12");
    adv_to(30); chk(pin, 1'b0, "R12");
    adv_to(42); chk(pin, 1'b1, "R12");
    adv_to(43); chk(pin, 1'b0, "R12");

    // R9: update coincides with the fall compare, pin high
    start(20, 6);
    adv_to(5); upd_req = 1'b1; step();
    chk(pin, 1'b1, "R9"); chk(irq, 1'b1, "R9");
    adv_to(11); chk(pin, 1'b1, "R9");
    adv_to(12); chk(pin, 1'b0, "R9"); chk(irq, 1'b0, "R9");
    adv_to(25); chk(pin, 1'b0, "R9");
    adv_to(26); chk(pin, 1'b1, "R9"); chk(irq, 1'b1, "R9");

    // R10: update coincides with the zero-duty period compare, pin low
    start(10, 0);
    adv_to(4); set_wr(2, 4); step();
    adv_to(9); upd_req = 1'b1; step();
    chk(irq, 1'b1, "R10"); chk(pin, 1'b0, "R10");
    adv_to(19); chk(pin, 1'b0, "R10");
    adv_to(20); chk(pin, 1'b1, "R10"); chk(irq, 1'b1, "R10");
    adv_to(23); chk(pin, 1'b1, "R10");
    adv_to(24); chk(pin, 1'b0, "R10");

    // R6: full duty returns to normal at the period compare
    start(10, 10);
    adv_to(4); set_wr(2, 3); step();
    adv_to(10); chk(pin, 1'b1, "R6"); chk(irq, 1'b1, "R6");
    adv_to(12); chk(pin, 1'b1, "R6");
    adv_to(13); chk(pin, 1'b0, "R6");
    adv_to(20); chk(pin, 1'b1, "R6"); chk(irq, 1'b1, "R6");

    // R6: zero duty returns to normal one period after the compare
    start(10, 0);
    adv_to(4); set_wr(2, 6); step();
    adv_to(10); chk(pin, 1'b0, "R6"); chk(irq, 1'b1, "R6");
    adv_to(19); chk(pin, 1'b0, "R6");
    adv_to(20); chk(pin, 1'b1, "R6");
    adv_to(26); chk(pin, 1'b0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule